// File: doc/BRIEF.md
# One-Time-Programmable Region Lock Controller

This block holds a 1024-byte one-time-programmable space and rules on every byte program request sent to it. The space is cut into 32 regions of 32 bytes each. The region index is taken from address bits [9:5]. A program can only move bits from 1 to 0, because the stored byte becomes the old byte ANDed with the new byte. No erase operation exists.

Protection state is kept inside the space itself. The bottom 16 bytes of region 0 carry a factory value that is loaded from a parameter at reset, and the host can never program them. The next four bytes carry one lock bit per region, and the host clears a lock bit by programming an ordinary byte. Above the lock bytes sit twelve reserved bytes that the host may program. A sticky freeze bit shuts off all programming until reset.

Each request has a 10-bit address. A read returns its byte one cycle later. A program request yields exactly one one-cycle pulse, either done or error.

Top module: `otp_guard`

## Requirements
- R1: After reset, bytes 0x00–0x0F hold the bytes of FACTORY_VALUE, with byte i equal to FACTORY_VALUE[8i+7:8i]. Every other byte reads 0xFF. rdata, wr_done and wr_err are 0.
- R2: rd_en sampled at an edge puts the byte at addr on rdata after that edge. rdata keeps its value while rd_en is low.
- R3: An accepted program request stores old AND wdata at addr, so bits never return from 0 to 1. It pulses wr_done for the one cycle after the request edge.
- R4: A program request to addresses 0x00–0x0F is always rejected. It pulses wr_err and leaves memory unchanged.
- R5: The lock bit of region n is bit (n & 7) of byte 0x10 + (n >> 3). A value of 0 rejects every program request to that region, and a value of 1 leaves the region programmable.
- R6: Bytes 0x10–0x1F belong to region 0 and follow its lock bit. While that bit is 1, the reserved bytes 0x14–0x1F and the lock bytes are programmable. Once it is 0, the lock bytes can no longer be changed.
- R7: A pulse on freeze_set rejects every program request from the next edge until reset. A program request in the same cycle as the pulse is still judged without the freeze. Reads are not affected by the freeze.
- R8: Each program request produces exactly one of wr_done and wr_err, one cycle later. Neither pulses in any cycle after an edge without a program request.
- R9: When a read and a program hit the same address in the same cycle, the read returns the byte as it was before the program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; reloads contents and clears freeze |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Program request |
| addr | input | 10 | Byte address for the read and the program |
| wdata | input | 8 | Program data; bits at 0 clear stored bits |
| freeze_set | input | 1 | Sets the sticky freeze |
| rdata | output | 8 | Read data, one cycle after rd_en |
| wr_done | output | 1 | One-cycle pulse for an accepted program |
| wr_err | output | 1 | One-cycle pulse for a rejected program |

## Verification
The assertions treat rd_en, wr_en, addr, wdata and freeze_set as synchronous inputs that settle before each rising edge. The freeze assertion keeps its own record of a freeze_set pulse since reset, so it relies on reset being the only way to clear the freeze. The bench changes inputs only on falling edges and samples the registered outputs on the following falling edge. It returns every request line to 0 between operations, except in the cycles where a combined read and program, or a program together with freeze_set, is the thing under test.

// File: rtl/otp_guard.sv
module otp_guard #(
  parameter int ADDR_W = 10,
  parameter int REGION_BITS = 5,
  parameter int FACTORY_BYTES = 16,
  parameter int LOCK_OFFSET = 16,
  parameter logic [8*FACTORY_BYTES-1:0] FACTORY_VALUE = 128'h0123456789ABCDEF_FEDCBA9876543210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              freeze_set,
  output logic [7:0]        rdata,
  output logic              wr_done,
  output logic              wr_err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int REGIONS = DEPTH >> REGION_BITS;
  localparam int REG_W = ADDR_W - REGION_BITS;
  localparam int LOCK_BYTES = (REGIONS + 7) / 8;

  logic [7:0] mem [DEPTH];
  logic frozen;
  logic [8*LOCK_BYTES-1:0] lock_vec;
  logic [REG_W-1:0] region;
  logic factory_hit, allow;

  function automatic logic [7:0] init_byte(int idx);
    logic [8*FACTORY_BYTES-1:0] sh;
    sh = FACTORY_VALUE >> (8 * idx);
    return (idx < FACTORY_BYTES) ? sh[7:0] : 8'hFF;
  endfunction

  for (genvar k = 0; k < LOCK_BYTES; k++) begin : g_lock
    assign lock_vec[8*k +: 8] = mem[LOCK_OFFSET + k];
  end

  assign region      = addr[ADDR_W-1:REGION_BITS];
  assign factory_hit = addr < ADDR_W'(FACTORY_BYTES);
  assign allow       = !frozen && !factory_hit && lock_vec[region];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i);
    end else if (wr_en && allow) begin
      mem[addr] <= mem[addr] & wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen  <= 1'b0;
      rdata   <= '0;
      wr_done <= 1'b0;
      wr_err  <= 1'b0;
    end else begin
      if (freeze_set) frozen <= 1'b1;
      if (rd_en) rdata <= mem[addr];
      wr_done <= wr_en && allow;
      wr_err  <= wr_en && !allow;
    end
  end
endmodule

module otp_guard_chk #(
  parameter int ADDR_W = 10,
  parameter int FACTORY_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              freeze_set,
  input logic [7:0]        rdata,
  input logic              wr_done,
  input logic              wr_err
);
  logic seen_freeze;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_freeze <= 1'b0;
    else if (freeze_set) seen_freeze <= 1'b1;

  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $countones({wr_done, wr_err}) == 1);
  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !wr_done && !wr_err);
  assert_factory_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr < ADDR_W'(FACTORY_BYTES)) |=> wr_err);
  assert_freeze_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_freeze && wr_en |=> wr_err && !wr_done);
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind otp_guard otp_guard_chk #(.ADDR_W(ADDR_W), .FACTORY_BYTES(FACTORY_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .freeze_set(freeze_set), .rdata(rdata), .wr_done(wr_done), .wr_err(wr_err));

// File: tb/otp_guard_tb.sv
module otp_guard_tb;
  localparam logic [127:0] FV = 128'h0123456789ABCDEF_FEDCBA9876543210;

  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0, freeze_set = 0;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic wr_done, wr_err;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  otp_guard u_dut (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .freeze_set(freeze_set), .rdata(rdata), .wr_done(wr_done), .wr_err(wr_err));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input bit rd, input bit wr, input bit fz, input logic [9:0] a,
                    input logic [7:0] d, output logic [7:0] q, output logic dn, output logic er);
    @(negedge clk);
    rd_en = rd; wr_en = wr; freeze_set = fz; addr = a; wdata = d;
    @(negedge clk);
    rd_en = 0; wr_en = 0; freeze_set = 0;
    q = rdata; dn = wr_done; er = wr_err;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] q);
    logic dn, er;
    op(1, 0, 0, a, 8'h00, q, dn, er);
  endtask

  task automatic prog(string req, input logic [9:0] a, input logic [7:0] d, input bit ok);
    logic [7:0] q; logic dn, er;
    op(0, 1, 0, a, d, q, dn, er);
    check({req, " done"}, {7'd0, dn}, {7'd0, ok});
    check({req, " err"}, {7'd0, er}, {7'd0, !ok});
  endtask

  task automatic do_reset;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset;
    logic [7:0] q;
    check("R1 rdata", rdata, 8'h00);
    check("R1 done/err", {6'd0, wr_done, wr_err}, 8'h00);
    for (int i = 0; i < 16; i += 5) begin
      rd(10'(i), q); check("R1 factory", q, FV[8*i +: 8]);
    end
    rd(10'h00F, q); check("R1 factory top", q, FV[127:120]);
    rd(10'h010, q); check("R1 lock erased", q, 8'hFF);
    rd(10'h3FF, q); check("R1 last byte", q, 8'hFF);
    repeat (2) @(negedge clk);
    check("R2 hold", rdata, 8'hFF);
  endtask

  task automatic t_program;
    logic [7:0] q;
    prog("R3 first", 10'h025, 8'hF0, 1);
    rd(10'h025, q); check("R3 data", q, 8'hF0);
    prog("R3 and", 10'h025, 8'h3C, 1);
    rd(10'h025, q); check("R3 and data", q, 8'h30);
    prog("R3 no raise", 10'h025, 8'hFF, 1);
    rd(10'h025, q); check("R3 no raise data", q, 8'h30);
  endtask

  task automatic t_factory;
    logic [7:0] q;
    prog("R4 low", 10'h005, 8'h00, 0);
    rd(10'h005, q); check("R4 unchanged", q, FV[47:40]);
    prog("R4 edge", 10'h00F, 8'h00, 0);
    rd(10'h00F, q); check("R4 edge unchanged", q, FV[127:120]);
  endtask

  task automatic t_lock;
    logic [7:0] q;
    prog("R5 lock r3", 10'h010, 8'hF7, 1);
    prog("R5 r3 blocked", 10'h060, 8'h00, 0);
    rd(10'h060, q); check("R5 r3 unchanged", q, 8'hFF);
    prog("R5 lock r9", 10'h011, 8'hFD, 1);
    prog("R5 r9 blocked", 10'h13F, 8'h00, 0);
    prog("R5 r4 open", 10'h080, 8'h5A, 1);
    rd(10'h080, q); check("R5 r4 data", q, 8'h5A);
  endtask

  task automatic t_region0;
    logic [7:0] q;
    prog("R6 reserved", 10'h015, 8'hAA, 1);
    rd(10'h015, q); check("R6 reserved data", q, 8'hAA);
    prog("R6 lock r0", 10'h010, 8'hFE, 1);
    rd(10'h010, q); check("R6 lock byte", q, 8'hF6);
    prog("R6 lock bytes frozen", 10'h012, 8'h00, 0);
    rd(10'h012, q); check("R6 lock byte kept", q, 8'hFF);
    prog("R6 reserved locked", 10'h01F, 8'h00, 0);
    prog("R6 r1 open", 10'h030, 8'h55, 1);
  endtask

  task automatic t_same;
    logic [7:0] q; logic dn, er;
    op(1, 1, 0, 10'h040, 8'h0F, q, dn, er);
    check("R9 old value", q, 8'hFF);
    check("R9 done", {7'd0, dn}, 8'h01);
    rd(10'h040, q); check("R9 new value", q, 8'h0F);
  endtask

  task automatic t_freeze;
    logic [7:0] q; logic dn, er;
    op(0, 1, 1, 10'h201, 8'h11, q, dn, er);
    check("R7 same-cycle accepted", {7'd0, dn}, 8'h01);
    prog("R7 frozen", 10'h202, 8'h00, 0);
    rd(10'h202, q); check("R7 unchanged", q, 8'hFF);
    rd(10'h025, q); check("R7 read ok", q, 8'h30);
    repeat (5) @(negedge clk);
    prog("R7 sticky", 10'h3C0, 8'h00, 0);
    do_reset();
    rd(10'h201, q); check("R1 reload", q, 8'hFF);
    prog("R7 cleared by reset", 10'h202, 8'h0F, 1);
    rd(10'h202, q); check("R7 after reset data", q, 8'h0F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    t_reset();
    t_program();
    t_factory();
    t_lock();
    t_region0();
    t_same();
    t_freeze();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule